// File: doc/BRIEF.md
# Per-Pin Power-of-Two Input Debouncer

This block filters a group of already synchronised input pins before their levels reach the input status register and the edge detector. Each pin has its own 32-bit control word. One enable bit in that word selects between a plain pass-through and a filter. When filtering is on, a small exponent field sets how long the raw input must hold a new level before the filtered output takes it. That time is a power of two in milliseconds.

Time is measured in pulses of a shared one-millisecond tick. The tick is a single-clock strobe supplied from outside. Each pin owns a small state machine and a tick counter. The state machine has three states:

- `PDB_BYPASS`: filtering is off and the output copies the input every clock.
- `PDB_HOLD`: filtering is on and the input agrees with the output.
- `PDB_WAIT`: filtering is on, the input disagrees with the output, and ticks are being counted.

The transitions are as follows:

- Leaving `PDB_BYPASS`: when the enable bit sets, the machine moves to `PDB_WAIT` if the input already differs from the output, and to `PDB_HOLD` otherwise.
- `PDB_HOLD` to `PDB_WAIT`: taken when the input starts to disagree with the output.
- `PDB_WAIT` back to `PDB_HOLD`: taken in two cases. Either the input returns to the output level, which abandons the count, or the final tick arrives, which accepts the new level.
- Disable: in any state, clearing the enable bit returns the machine to `PDB_BYPASS`.

Top module: `pin_debounce_bank`

## Requirements
- R1: While reset is asserted (rst_n low), every filtered output is 0.
- R2: When bit 8 of a pin's control word is 0, that pin's filtered output equals its raw input as sampled at the previous rising clock edge, whatever the period field holds.
- R3: When bit 8 is 1, a pin's filtered output never changes at a clock edge where the tick input is low.
- R4: When bit 8 is 1 and the raw input differs from the filtered output, the output takes the raw level at the edge that samples the 2^k-th tick. Here k is the unsigned value in control bits [7:5]. Ticks are counted from the edge after the first differing sample; a tick on that first edge is not counted.
- R5: With period code 0, a single counted tick accepts a new level.
- R6: If the raw input returns to the filtered level before acceptance, the output does not change. The count restarts from zero on the next difference.
- R7: A change of the period field while a pin is counting restarts its count. A tick on the edge where the change is seen is not counted.
- R8: With period code 7, acceptance needs 128 counted ticks: after 127 ticks the output is unchanged.
- R9: Control bits other than bit 8 and bits [7:5] have no effect on the filtered output.
- R10: Each pin is filtered independently: one pin's input, control word or count never affects another pin's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock strobe once per millisecond from the shared prescaler |
| raw_in | input | NPINS | Synchronised raw pin levels, bit p for pin p |
| pin_ctrl | input | NPINS*CTRL_W | Control words, pin p in bits [p*CTRL_W +: CTRL_W] |
| filt_out | output | NPINS | Filtered pin levels for status and edge detection |

## Verification
Directed cases cover several stimulus shapes, each aimed at one failure mode:

- Tick-counted acceptance at codes 0, 1, 2 and 7 exposes off-by-one errors in the power-of-two limit.
- A tick arriving on the same edge as the input change shows whether that tick is wrongly counted.
- A pulse that returns early separates a restarting counter from one that merely pauses.
- A period change in mid-count proves that the count restarts.
- Pass-through with garbage in the unused control bits shows that only the enable bit and the period field are decoded.

A long random run follows. It applies sparse input toggles, irregular ticks and periodic reconfiguration of all four pins. Every clock it compares the outputs against a bench model, which catches state-machine paths that the directed cases do not reach.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    // Per-pin filter state
    typedef enum logic [1:0] {
        PDB_BYPASS = 2'd0,  // filtering off, output copies input
        PDB_HOLD   = 2'd1,  // filtering on, input agrees with output
        PDB_WAIT   = 2'd2   // filtering on, counting ticks toward acceptance
    } pdb_state_e;

    // Decoded per-pin configuration
    typedef struct packed {
        logic       enable;
        logic [2:0] code;
    } pdb_cfg_t;

endpackage

// File: rtl/pdb_ctrl_decode.sv
module pdb_ctrl_decode #(
    parameter int CTRL_W   = 32,
    parameter int EN_BIT   = 8,
    parameter int CODE_LSB = 5,
    parameter int CODE_W   = 3
) (
    input  logic [CTRL_W-1:0] word,
    output logic              enable,
    output logic [CODE_W-1:0] code
);

    // Bits outside the enable and period field are not decoded
    logic unused_ctrl_bits;

    assign enable = word[EN_BIT];
    assign code   = word[CODE_LSB +: CODE_W];

    assign unused_ctrl_bits = ^{word[CTRL_W-1:EN_BIT+1], word[CODE_LSB-1:0]};

endmodule

// File: rtl/pdb_tick_count.sv
module pdb_tick_count #(
    parameter int CODE_W = 3,
    localparam int CNT_W = (1 << CODE_W) - 1,
    localparam int LIM_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [CODE_W-1:0] code,
    output logic              at_last
);

    logic [CNT_W-1:0] cnt_q;
    logic [LIM_W-1:0] span;

    // Number of ticks for this code: 2^code
    assign span    = LIM_W'(1) << code;
    assign at_last = ({1'b0, cnt_q} == (span - LIM_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pdb_pin_fsm.sv
module pdb_pin_fsm
    import pdb_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              raw,
    input  logic              enable,
    input  logic [CODE_W-1:0] code,
    input  logic              cnt_last,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              filt
);

    pdb_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              filt_q;
    logic              load_raw;
    logic              code_moved;
    logic              differs;

    assign code_moved = (code != code_q);
    assign differs    = (raw != filt_q);
    assign filt       = filt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PDB_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b1;
        cnt_inc  = 1'b0;
        load_raw = 1'b0;
        unique case (state_q)
            PDB_BYPASS: begin
                if (!enable) begin
                    load_raw = 1'b1;
                end else if (differs) begin
                    state_d = PDB_WAIT;
                end else begin
                    state_d = PDB_HOLD;
                end
            end
            PDB_HOLD: begin
                if (!enable) begin
                    state_d  = PDB_BYPASS;
                    load_raw = 1'b1;
                end else if (differs) begin
                    state_d = PDB_WAIT;
                end
            end
            PDB_WAIT: begin
                if (!enable) begin
                    state_d  = PDB_BYPASS;
                    load_raw = 1'b1;
                end else if (!differs) begin
                    state_d = PDB_HOLD;
                end else if (code_moved) begin
                    cnt_clr = 1'b1;
                end else if (tick && cnt_last) begin
                    load_raw = 1'b1;
                    state_d  = PDB_HOLD;
                end else begin
                    cnt_clr = 1'b0;
                    cnt_inc = tick;
                end
            end
            default: begin
                state_d = PDB_BYPASS;
            end
        endcase
    end

    // Filtered level and remembered period code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            code_q <= '0;
        end else begin
            code_q <= code;
            if (load_raw) begin
                filt_q <= raw;
            end
        end
    end

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank
    import pdb_pkg::*;
#(
    parameter int NPINS    = 4,
    parameter int CTRL_W   = 32,
    parameter int EN_BIT   = 8,
    parameter int CODE_LSB = 5,
    parameter int CODE_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ms_tick,
    input  logic [NPINS-1:0]        raw_in,
    input  logic [NPINS*CTRL_W-1:0] pin_ctrl,
    output logic [NPINS-1:0]        filt_out
);

    pdb_cfg_t   cfg [NPINS];
    logic [NPINS-1:0] en_vec;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic              en_p;
        logic [CODE_W-1:0] code_p;
        logic              clr_p;
        logic              inc_p;
        logic              last_p;

        pdb_ctrl_decode #(
            .CTRL_W  (CTRL_W),
            .EN_BIT  (EN_BIT),
            .CODE_LSB(CODE_LSB),
            .CODE_W  (CODE_W)
        ) u_decode (
            .word  (pin_ctrl[p*CTRL_W +: CTRL_W]),
            .enable(en_p),
            .code  (code_p)
        );

        assign cfg[p].enable = en_p;
        assign cfg[p].code   = 3'(code_p);
        assign en_vec[p]     = cfg[p].enable;

        pdb_tick_count #(
            .CODE_W(CODE_W)
        ) u_count (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_p),
            .inc    (inc_p),
            .code   (code_p),
            .at_last(last_p)
        );

        pdb_pin_fsm #(
            .CODE_W(CODE_W)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (ms_tick),
            .raw     (raw_in[p]),
            .enable  (en_p),
            .code    (code_p),
            .cnt_last(last_p),
            .cnt_clr (clr_p),
            .cnt_inc (inc_p),
            .filt    (filt_out[p])
        );
    end

    logic unused_cfg;
    assign unused_cfg = ^{cfg[0].code};

endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
    parameter int NPINS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ms_tick,
    input logic [NPINS-1:0] raw_in,
    input logic [NPINS-1:0] en_vec,
    input logic [NPINS-1:0] filt_out
);

    // R1: outputs are cleared while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (filt_out == '0);
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R2: pass-through copies the previous sample
        assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !en_vec[g] |=> (filt_out[g] == $past(raw_in[g])));

        // R3: no output change without a tick while filtering
        assert_no_tick_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_vec[g] && !ms_tick) |=> $stable(filt_out[g]));

        // R6: an input that agrees with the output cannot move it
        assert_agree_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (en_vec[g] && (raw_in[g] == filt_out[g])) |=> $stable(filt_out[g]));
    end

endmodule

bind pin_debounce_bank pdb_checker #(
    .NPINS(NPINS)
) u_pdb_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .raw_in  (raw_in),
    .en_vec  (en_vec),
    .filt_out(filt_out)
);

// File: tb/pin_debounce_bank_tb.sv
module pin_debounce_bank_tb;

    localparam int NP = 4;
    localparam int CW = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ms_tick = 1'b0;
    logic [NP-1:0]    raw_in = '0;
    logic [NP*CW-1:0] pin_ctrl = '0;
    logic [NP-1:0]    filt_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    pin_debounce_bank #(.NPINS(NP)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .raw_in  (raw_in),
        .pin_ctrl(pin_ctrl),
        .filt_out(filt_out)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Bench model state
    bit m_out  [NP];
    bit m_wait [NP];
    int m_cnt  [NP];
    int m_code [NP];

    function automatic int period_of(int code);
        return 1 << code;
    endfunction

    function automatic bit cfg_en(int p);
        return pin_ctrl[p*CW + 8];
    endfunction

    function automatic int cfg_code(int p);
        return int'(pin_ctrl[p*CW + 5 +: 3]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_out[p] = 1'b0; m_wait[p] = 1'b0; m_cnt[p] = 0; m_code[p] = 0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                int c;
                c = cfg_code(p);
                if (!cfg_en(p)) begin
                    m_out[p] = raw_in[p]; m_wait[p] = 1'b0; m_cnt[p] = 0;
                end else if (!m_wait[p]) begin
                    m_cnt[p] = 0;
                    if (raw_in[p] != m_out[p]) m_wait[p] = 1'b1;
                end else if (raw_in[p] == m_out[p]) begin
                    m_wait[p] = 1'b0; m_cnt[p] = 0;
                end else if (c != m_code[p]) begin
                    m_cnt[p] = 0;
                end else if (ms_tick) begin
                    if (m_cnt[p] == period_of(c) - 1) begin
                        m_out[p] = raw_in[p]; m_wait[p] = 1'b0; m_cnt[p] = 0;
                    end else begin
                        m_cnt[p] = m_cnt[p] + 1;
                    end
                end
                m_code[p] = c;
            end
        end
    end

    // Continuous comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int p = 0; p < NP; p++) begin
                n_tests++;
                if (filt_out[p] !== m_out[p]) begin
                    n_fail++;
                    $display("FAIL %s model pin %0d: got %0b expected %0b",
                             cfg_en(p) ? "R4" : "R2", p, filt_out[p], m_out[p]);
                end
            end
        end
    end

    task automatic chk(string req, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic set_cfg(int p, bit en, int code, logic [31:0] junk);
        logic [31:0] w;
        w = (junk & ~32'h0000_01E0) | (32'(en) << 8) | (32'(code & 7) << 5);
        pin_ctrl[p*CW +: CW] = w;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        n_tests++;
        if (filt_out !== '0) begin
            n_fail++;
            $display("FAIL R1: got %b expected 0000", filt_out);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 pass-through with a period code present; R10 neighbour untouched
        set_cfg(1, 1'b0, 7, 32'h0);
        raw_in[1] = 1'b1;
        @(negedge clk);
        chk("R2 bypass one clock", filt_out[1], 1'b1);
        chk("R10 neighbour pin0", filt_out[0], 1'b0);

        // R4 code 2 needs four ticks
        set_cfg(0, 1'b1, 2, $urandom);
        @(negedge clk);
        raw_in[0] = 1'b1;
        @(negedge clk);
        pulses(3);
        chk("R4 code2 after 3 ticks", filt_out[0], 1'b0);
        pulses(1);
        chk("R4 code2 after 4 ticks", filt_out[0], 1'b1);

        // R4 tick on the first differing edge is not counted (code 1)
        set_cfg(2, 1'b1, 1, $urandom);
        @(negedge clk);
        raw_in[2] = 1'b1;
        pulses(1);
        pulses(1);
        chk("R4 entry tick ignored", filt_out[2], 1'b0);
        pulses(1);
        chk("R4 code1 accepted", filt_out[2], 1'b1);

        // R5 code 0
        set_cfg(3, 1'b1, 0, $urandom);
        @(negedge clk);
        raw_in[3] = 1'b1;
        @(negedge clk);
        chk("R5 before tick", filt_out[3], 1'b0);
        pulses(1);
        chk("R5 single tick", filt_out[3], 1'b1);

        // R6 glitch returns early, then fresh count
        raw_in[0] = 1'b0;
        @(negedge clk);
        pulses(2);
        raw_in[0] = 1'b1;
        @(negedge clk);
        raw_in[0] = 1'b0;
        @(negedge clk);
        pulses(3);
        chk("R6 restarted count", filt_out[0], 1'b1);
        pulses(1);
        chk("R6 fresh count done", filt_out[0], 1'b0);

        // R7 period change mid-count
        raw_in[0] = 1'b1;
        @(negedge clk);
        pulses(3);
        set_cfg(0, 1'b1, 1, $urandom);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        pulses(1);
        chk("R7 after change 1 tick", filt_out[0], 1'b0);
        pulses(1);
        chk("R7 after change 2 ticks", filt_out[0], 1'b1);

        // R8 code 7 needs 128 ticks
        set_cfg(1, 1'b1, 7, $urandom);
        @(negedge clk);
        raw_in[1] = 1'b0;
        @(negedge clk);
        pulses(period_of(7) - 1);
        chk("R8 after 127 ticks", filt_out[1], 1'b1);
        pulses(1);
        chk("R8 after 128 ticks", filt_out[1], 1'b0);

        // R9 undecoded bits set, pass-through still exact
        set_cfg(3, 1'b0, 0, 32'hFFFF_FE1F);
        raw_in[3] = 1'b0;
        @(negedge clk);
        chk("R9 junk bits bypass", filt_out[3], 1'b0);
        set_cfg(3, 1'b1, 0, 32'hFFFF_FE1F);
        raw_in[3] = 1'b1;
        @(negedge clk);
        chk("R9 junk bits hold", filt_out[3], 1'b0);
        pulses(1);
        chk("R9 junk bits accept", filt_out[3], 1'b1);
        chk("R10 pin2 unaffected", filt_out[2], 1'b1);

        // Random phase checked by the model every clock
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 200 == 0) begin
                for (int p = 0; p < NP; p++) begin
                    set_cfg(p, ($urandom % 4) != 0, $urandom % 4, $urandom);
                end
            end
            ms_tick = ($urandom % 4) == 0;
            for (int p = 0; p < NP; p++) begin
                if (($urandom % 6) == 0) raw_in[p] = ~raw_in[p];
            end
            @(negedge clk);
        end
        ms_tick = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule